// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error Flags

This block receives asynchronous serial words. It samples the line once per pulse of a sixteen-times-oversampling tick. It confirms each start bit at its centre, then samples every later bit at its centre. The bits it assembles go into a one-word receive buffer, and a ready flag marks when that buffer holds a word. Word length and parity follow the same configuration inputs that the companion transmitter uses. Those inputs allow five to eight data bits, with no parity, even parity, odd parity, or a parity bit fixed at 1 or 0.

The receiver keeps four sticky error indications: parity mismatch, bad stop bit, line break, and overrun. A data-read strobe empties the buffer. A status-read strobe clears the error indications. A loopback control feeds the transmitter's serial bit into the receiver in place of the external line, and it holds the external transmit pin at mark. The selected input passes through a short synchroniser before the sampler sees it.

Top module: `serial_rx_core`

## Requirements
- R1: After a synchronous reset, `word_ready`, `rx_word` and all four error outputs are 0. When `loop_mode` is 0, `ser_out` follows `tx_bit`.
- R2: A low level seen on a tick only starts a frame if the line is still low 8 ticks later. If the line is high there, the low is dropped as a glitch: no word, no flag.
- R3: Data bits arrive least significant bit first. `cfg_wlen` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 bits. Bits above the word length read as 0 in `rx_word`.
- R4: `word_ready` rises when a word is stored and falls after a `read_data` pulse. If a word completes in the same cycle as a read, the new word is stored and `word_ready` stays 1.
- R5: When `cfg_par_en` is 1, one parity bit follows the data. The expected value gives an even count of ones when `cfg_par_even` is 1 and an odd count when it is 0. With `cfg_par_fixed` set, the expected value is 1 when `cfg_par_even` is 0 and 0 when it is 1. A mismatch sets `err_parity`.
- R6: Only one stop bit is sampled. If it reads 0, `err_frame` is set and the word is still stored. A new start bit may follow that single stop bit at once.
- R7: If start, data, parity and stop bits all sample as 0, `err_break` is set and no word is stored. No new start is accepted until the line has been seen high.
- R8: If a word completes while `word_ready` is 1 and no read arrives in that cycle, `err_overrun` is set. The unread word in `rx_word` is kept, and the new word is lost.
- R9: When `loop_mode` is 1, the receiver samples `tx_bit`, `ser_in` has no effect, and `ser_out` is 1.
- R10: A `read_status` pulse clears all four error flags. If a new error arrives in the same cycle, that error stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | One-cycle pulse at sixteen times the bit rate |
| ser_in | input | 1 | External serial input |
| tx_bit | input | 1 | Serial bit from the companion transmitter |
| loop_mode | input | 1 | 1 routes `tx_bit` to the receiver and forces `ser_out` to mark |
| cfg_wlen | input | 2 | Word length code (5 + code bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Even parity; with fixed parity, selects fixed 0 |
| cfg_par_fixed | input | 1 | Parity bit has a fixed value |
| read_data | input | 1 | Pulse: the buffered word is taken |
| read_status | input | 1 | Pulse: the error flags are taken |
| ser_out | output | 1 | External serial output |
| rx_word | output | 8 | Receive buffer, zero-extended |
| word_ready | output | 1 | Buffer holds an unread word |
| err_parity | output | 1 | Sticky parity mismatch |
| err_frame | output | 1 | Sticky stop-bit error |
| err_break | output | 1 | Sticky break indication |
| err_overrun | output | 1 | Sticky overrun |

## Verification
The test sends words of every length and covers each parity flavour. Each flavour is sent once with a correct parity bit and once with a wrong one, so a swapped parity sense or a wrong fixed value shows up. Short low pulses are used to check that start validation rejects glitches. Frames with a low stop bit are compared against frames held low for a full frame, to separate framing errors from breaks. Two back-to-back words are sent twice: once unread, which must overrun and keep the first word, and once with a read between them, which must not overrun. A loopback frame is sent while the external input sits at 0, which shows whether the input selection really ignores that pin.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int unsigned RX_WORD_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_HOLD
    } rx_phase_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       par_even;
        logic       par_fixed;
    } rx_cfg_t;

    typedef struct packed {
        logic [RX_WORD_W-1:0] word;
        logic                 par_bad;
        logic                 frame_bad;
    } rx_frame_t;

    function automatic logic [3:0] data_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    // Expected parity bit; the word is already zero-filled above its length.
    function automatic logic parity_target(input rx_cfg_t c, input logic [RX_WORD_W-1:0] w);
        if (c.par_fixed) begin
            return ~c.par_even;
        end
        return c.par_even ? (^w) : ~(^w);
    endfunction

endpackage

// File: rtl/rx_line_path.sv
module rx_line_path #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_in,
    input  logic tx_bit,
    input  logic loop_mode,
    output logic ser_out,
    output logic line_s
);

    logic                   sel_line;
    logic [SYNC_STAGES-1:0] sync_q;

    assign sel_line = loop_mode ? tx_bit : ser_in;
    assign ser_out  = loop_mode ? 1'b1 : tx_bit;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= sel_line;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], sel_line};
            end
        end
    endgenerate

    assign line_s = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import serial_rx_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      line_s,
    input  rx_cfg_t   cfg,
    output logic      word_done,
    output logic      brk_evt,
    output rx_frame_t frame
);

    localparam int unsigned CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);

    rx_phase_e            phase;
    logic [CNT_W-1:0]     cnt;
    logic [2:0]           idx;
    logic [RX_WORD_W-1:0] shreg;
    logic                 all_zero;
    logic                 par_bit;
    logic                 last_data;

    assign last_data = ({1'b0, idx} == (data_bits(cfg.wlen) - 4'd1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= RX_IDLE;
            cnt       <= '0;
            idx       <= '0;
            shreg     <= '0;
            all_zero  <= 1'b0;
            par_bit   <= 1'b0;
            word_done <= 1'b0;
            brk_evt   <= 1'b0;
            frame     <= '0;
        end else begin
            word_done <= 1'b0;
            brk_evt   <= 1'b0;
            if (tick) begin
                unique case (phase)
                    RX_IDLE: begin
                        if (!line_s) begin
                            phase <= RX_START;
                            cnt   <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt == MID_CNT) begin
                            cnt <= '0;
                            if (line_s) begin
                                phase <= RX_IDLE;
                            end else begin
                                phase    <= RX_DATA;
                                idx      <= '0;
                                shreg    <= '0;
                                all_zero <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt == LAST_CNT) begin
                            cnt        <= '0;
                            shreg[idx] <= line_s;
                            all_zero   <= all_zero & ~line_s;
                            if (last_data) phase <= cfg.par_en ? RX_PARITY : RX_STOP;
                            else           idx   <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_PARITY: begin
                        if (cnt == LAST_CNT) begin
                            cnt      <= '0;
                            par_bit  <= line_s;
                            all_zero <= all_zero & ~line_s;
                            phase    <= RX_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt == LAST_CNT) begin
                            cnt <= '0;
                            if (all_zero && !line_s) begin
                                brk_evt <= 1'b1;
                                phase   <= RX_HOLD;
                            end else begin
                                word_done       <= 1'b1;
                                frame.word      <= shreg;
                                frame.frame_bad <= ~line_s;
                                frame.par_bad   <= cfg.par_en &&
                                                   (par_bit != parity_target(cfg, shreg));
                                phase           <= RX_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_HOLD: begin
                        if (line_s) phase <= RX_IDLE;
                    end
                    default: phase <= RX_IDLE;
                endcase
            end
        end
    end

    AST_GLITCH_IDLE: assert property (@(posedge clk) disable iff (rst)
        (phase == RX_IDLE && tick && line_s) |=> (phase == RX_IDLE)); // R2

    AST_EVT_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({word_done, brk_evt})); // R7

    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
        (phase == RX_HOLD && !line_s) |=> (phase == RX_HOLD)); // R7

endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
    import serial_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 word_done,
    input  logic                 brk_evt,
    input  rx_frame_t            frame,
    input  logic                 read_data,
    input  logic                 read_status,
    output logic [RX_WORD_W-1:0] rx_word,
    output logic                 word_ready,
    output logic                 err_parity,
    output logic                 err_frame,
    output logic                 err_break,
    output logic                 err_overrun
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_word     <= '0;
            word_ready  <= 1'b0;
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            err_break   <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            if (read_data) word_ready <= 1'b0;
            if (read_status) begin
                err_parity  <= 1'b0;
                err_frame   <= 1'b0;
                err_break   <= 1'b0;
                err_overrun <= 1'b0;
            end
            if (word_done) begin
                if (word_ready && !read_data) begin
                    err_overrun <= 1'b1;
                end else begin
                    rx_word    <= frame.word;
                    word_ready <= 1'b1;
                end
                if (frame.par_bad)   err_parity <= 1'b1;
                if (frame.frame_bad) err_frame  <= 1'b1;
            end
            if (brk_evt) err_break <= 1'b1;
        end
    end

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (read_data && !word_done) |=> !word_ready); // R4

    AST_OVR_KEEP: assert property (@(posedge clk) disable iff (rst)
        (word_done && word_ready && !read_data) |=> (err_overrun && $stable(rx_word))); // R8

    AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (read_status && !word_done && !brk_evt) |=>
        !(err_parity || err_frame || err_break || err_overrun)); // R10

    AST_BRK_NO_WORD: assert property (@(posedge clk) disable iff (rst)
        brk_evt |=> $stable(rx_word)); // R7

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serial_rx_pkg::*;
#(
    parameter int unsigned OSR         = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_tick,
    input  logic                 ser_in,
    input  logic                 tx_bit,
    input  logic                 loop_mode,
    input  logic [1:0]           cfg_wlen,
    input  logic                 cfg_par_en,
    input  logic                 cfg_par_even,
    input  logic                 cfg_par_fixed,
    input  logic                 read_data,
    input  logic                 read_status,
    output logic                 ser_out,
    output logic [RX_WORD_W-1:0] rx_word,
    output logic                 word_ready,
    output logic                 err_parity,
    output logic                 err_frame,
    output logic                 err_break,
    output logic                 err_overrun
);

    rx_cfg_t   cfg;
    rx_frame_t frame;
    logic      line_s;
    logic      word_done;
    logic      brk_evt;

    assign cfg = '{wlen: cfg_wlen, par_en: cfg_par_en,
                   par_even: cfg_par_even, par_fixed: cfg_par_fixed};

    rx_line_path #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk       (clk),
        .rst       (rst),
        .ser_in    (ser_in),
        .tx_bit    (tx_bit),
        .loop_mode (loop_mode),
        .ser_out   (ser_out),
        .line_s    (line_s)
    );

    rx_frame_fsm #(.OSR(OSR)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tick      (sample_tick),
        .line_s    (line_s),
        .cfg       (cfg),
        .word_done (word_done),
        .brk_evt   (brk_evt),
        .frame     (frame)
    );

    rx_status_regs u_stat (
        .clk         (clk),
        .rst         (rst),
        .word_done   (word_done),
        .brk_evt     (brk_evt),
        .frame       (frame),
        .read_data   (read_data),
        .read_status (read_status),
        .rx_word     (rx_word),
        .word_ready  (word_ready),
        .err_parity  (err_parity),
        .err_frame   (err_frame),
        .err_break   (err_break),
        .err_overrun (err_overrun)
    );

    AST_SER_MARK: assert property (@(posedge clk) disable iff (rst)
        loop_mode |-> ser_out); // R9

endmodule

// File: tb/serial_rx_core_test.sv
module serial_rx_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 2;
    localparam int BIT_CLK    = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_tick = 1'b0;
    logic       ser_in = 1'b1;
    logic       tx_bit = 1'b1;
    logic       loop_mode = 1'b0;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_par_fixed = 1'b0;
    logic       read_data = 1'b0;
    logic       read_status = 1'b0;
    logic       ser_out;
    logic [7:0] rx_word;
    logic       word_ready, err_parity, err_frame, err_break, err_overrun;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit cmp_on = 1'b0;

    serial_rx_core uut (
        .clk(clk), .rst(rst), .sample_tick(sample_tick), .ser_in(ser_in),
        .tx_bit(tx_bit), .loop_mode(loop_mode), .cfg_wlen(cfg_wlen),
        .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_par_fixed(cfg_par_fixed), .read_data(read_data),
        .read_status(read_status), .ser_out(ser_out), .rx_word(rx_word),
        .word_ready(word_ready), .err_parity(err_parity), .err_frame(err_frame),
        .err_break(err_break), .err_overrun(err_overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) sample_tick <= ~sample_tick;

    function automatic logic bpar(input logic [7:0] d, input int nb,
                                  input logic even, input logic fixed);
        int ones = 0;
        for (int i = 0; i < nb; i++) ones += int'(d[i]);
        if (fixed) return !even;
        return even ? logic'(ones % 2) : logic'(!(ones % 2));
    endfunction

    // Behavioural reference: line history, bit-timing counters, buffer and flags
    int         m_ph, m_cnt, m_idx;
    logic [7:0] m_sh, m_buf, m_rdata;
    logic       m_allz, m_pb, m_done, m_brk, m_rp, m_rf;
    logic       m_rdy, m_pe, m_fe, m_be, m_ov;
    logic       m_hist[$];

    always @(posedge clk) begin
        logic s;
        int   nb;
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_idx = 0; m_sh = 0; m_buf = 0; m_rdata = 0;
            m_allz = 0; m_pb = 0; m_done = 0; m_brk = 0; m_rp = 0; m_rf = 0;
            m_rdy = 0; m_pe = 0; m_fe = 0; m_be = 0; m_ov = 0;
            m_hist = '{1'b1, 1'b1};
        end else begin
            if (read_data) m_rdy = 0;
            if (read_status) begin m_pe = 0; m_fe = 0; m_be = 0; m_ov = 0; end
            if (m_done) begin
                if (m_rdy) m_ov = 1;
                else begin m_buf = m_rdata; m_rdy = 1; end
                if (m_rp) m_pe = 1;
                if (m_rf) m_fe = 1;
            end
            if (m_brk) m_be = 1;
            m_done = 0; m_brk = 0;
            s = m_hist.pop_front();
            m_hist.push_back(loop_mode ? tx_bit : ser_in);
            nb = 5 + int'(cfg_wlen);
            if (sample_tick) begin
                case (m_ph)
                    0: if (!s) begin m_ph = 1; m_cnt = 0; end
                    1: if (m_cnt == 7) begin
                           m_cnt = 0;
                           if (s) m_ph = 0;
                           else begin m_ph = 2; m_idx = 0; m_sh = 0; m_allz = 1; end
                       end else m_cnt++;
                    2: if (m_cnt == 15) begin
                           m_cnt = 0; m_sh[m_idx] = s; if (s) m_allz = 0;
                           if (m_idx == nb - 1) m_ph = cfg_par_en ? 3 : 4;
                           else m_idx++;
                       end else m_cnt++;
                    3: if (m_cnt == 15) begin
                           m_cnt = 0; m_pb = s; if (s) m_allz = 0; m_ph = 4;
                       end else m_cnt++;
                    4: if (m_cnt == 15) begin
                           m_cnt = 0;
                           if (m_allz && !s) begin m_brk = 1; m_ph = 5; end
                           else begin
                               m_done = 1; m_rdata = m_sh; m_rf = !s;
                               m_rp = cfg_par_en && (m_pb != bpar(m_sh, nb, cfg_par_even, cfg_par_fixed));
                               m_ph = 0;
                           end
                       end else m_cnt++;
                    default: if (s) m_ph = 0;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Every-cycle comparison against the reference, between edges
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (cmp_on) begin
            chk("R3 rx_word vs model", rx_word, m_buf);
            chk("R4 word_ready vs model", {7'd0, word_ready}, {7'd0, m_rdy});
            chk("R5 err_parity vs model", {7'd0, err_parity}, {7'd0, m_pe});
            chk("R6 err_frame vs model", {7'd0, err_frame}, {7'd0, m_fe});
            chk("R7 err_break vs model", {7'd0, err_break}, {7'd0, m_be});
            chk("R8 err_overrun vs model", {7'd0, err_overrun}, {7'd0, m_ov});
            chk("R9 ser_out vs model", {7'd0, ser_out}, {7'd0, loop_mode ? 1'b1 : tx_bit});
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL R1 watchdog expired got %0d cycles expected fewer than 150000", cyc);
            finish_run();
        end
    end

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    task automatic hold_bit(input logic v, input bit lp, input int n);
        repeat (n) begin
            @(negedge clk);
            if (lp) tx_bit = v; else ser_in = v;
        end
    endtask

    task automatic send(input logic [7:0] d, input int nb, input bit pe,
                        input logic pb, input bit good_stop, input bit lp);
        hold_bit(1'b0, lp, BIT_CLK);
        for (int i = 0; i < nb; i++) hold_bit(d[i], lp, BIT_CLK);
        if (pe) hold_bit(pb, lp, BIT_CLK);
        if (good_stop) hold_bit(1'b1, lp, BIT_CLK);
        else begin hold_bit(1'b0, lp, 24); hold_bit(1'b1, lp, 8); end
    endtask

    task automatic pulse(input bit d, input bit s);
        @(negedge clk);
        read_data = d; read_status = s;
        @(negedge clk);
        read_data = 1'b0; read_status = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] wl, input bit pe, input bit ev, input bit fx);
        @(negedge clk);
        cfg_wlen = wl; cfg_par_en = pe; cfg_par_even = ev; cfg_par_fixed = fx;
    endtask

    initial begin
        logic [7:0] caught;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        cmp_on = 1'b1;
        settle();
        chk("R1 reset rx_word", rx_word, 8'h00);
        chk("R1 reset flags", {3'd0, word_ready, err_parity, err_frame, err_break, err_overrun}, 8'h00);
        chk("R1 ser_out follows tx_bit", {7'd0, ser_out}, 8'h01);
        @(negedge clk); tx_bit = 1'b0;
        settle();
        chk("R9 ser_out passes tx_bit low", {7'd0, ser_out}, 8'h00);
        @(negedge clk); tx_bit = 1'b1;

        // 8 data bits, no parity
        send(8'hA5, 8, 0, 0, 1, 0);
        hold_bit(1'b1, 0, 48);
        settle();
        chk("R3 8-bit word", rx_word, 8'hA5);
        chk("R4 ready after word", {7'd0, word_ready}, 8'h01);
        pulse(1, 0);
        settle();
        chk("R4 ready cleared by read", {7'd0, word_ready}, 8'h00);

        // 7 bits, even parity, correct bit
        set_cfg(2'd2, 1, 1, 0);
        send(8'h5B, 7, 1, bpar(8'h5B, 7, 1, 0), 1, 0);
        hold_bit(1'b1, 0, 48);
        settle();
        chk("R3 7-bit word", rx_word, 8'h5B);
        chk("R5 even parity ok", {7'd0, err_parity}, 8'h00);
        pulse(1, 0);

        // 6 bits, odd parity, wrong bit
        set_cfg(2'd1, 1, 0, 0);
        send(8'h2C, 6, 1, !bpar(8'h2C, 6, 0, 0), 1, 0);
        hold_bit(1'b1, 0, 48);
        settle();
        chk("R3 6-bit word", rx_word, 8'h2C);
        chk("R5 odd parity mismatch", {7'd0, err_parity}, 8'h01);
        pulse(1, 1);
        settle();
        chk("R10 status read clears parity", {7'd0, err_parity}, 8'h00);

        // 5 bits, fixed parity 1, upper bits of the sent byte ignored
        set_cfg(2'd0, 1, 0, 1);
        send(8'hF3, 5, 1, 1'b1, 1, 0);
        hold_bit(1'b1, 0, 48);
        settle();
        chk("R3 5-bit zero fill", rx_word, 8'h13);
        chk("R5 fixed-1 parity ok", {7'd0, err_parity}, 8'h00);
        pulse(1, 0);
        set_cfg(2'd0, 1, 1, 1);
        send(8'h0E, 5, 1, 1'b1, 1, 0);
        hold_bit(1'b1, 0, 48);
        settle();
        chk("R5 fixed-0 parity mismatch", {7'd0, err_parity}, 8'h01);
        pulse(1, 1);

        // Stop bit sampled low
        set_cfg(2'd3, 0, 0, 0);
        send(8'h3C, 8, 0, 0, 0, 0);
        hold_bit(1'b1, 0, 64);
        settle();
        chk("R6 framing error", {7'd0, err_frame}, 8'h01);
        chk("R6 word kept on framing error", rx_word, 8'h3C);
        pulse(1, 1);
        settle();
        chk("R10 framing cleared", {7'd0, err_frame}, 8'h00);

        // Short low pulse
        hold_bit(1'b0, 0, 6);
        hold_bit(1'b1, 0, 64);
        settle();
        chk("R2 glitch gives no word", {7'd0, word_ready}, 8'h00);
        chk("R2 glitch gives no flag", {4'd0, err_parity, err_frame, err_break, err_overrun}, 8'h00);

        // Two words, nothing read
        send(8'h11, 8, 0, 0, 1, 0);
        send(8'h22, 8, 0, 0, 1, 0);
        hold_bit(1'b1, 0, 48);
        settle();
        chk("R8 overrun flag", {7'd0, err_overrun}, 8'h01);
        chk("R8 first word kept", rx_word, 8'h11);
        pulse(1, 1);
        settle();
        chk("R10 overrun cleared", {7'd0, err_overrun}, 8'h00);

        // Two words back to back with a read between them
        fork
            begin
                send(8'h77, 8, 0, 0, 1, 0);
                send(8'h88, 8, 0, 0, 1, 0);
            end
            begin
                wait (word_ready);
                settle();
                caught = rx_word;
                pulse(1, 0);
            end
        join
        hold_bit(1'b1, 0, 48);
        settle();
        chk("R6 first of back-to-back", caught, 8'h77);
        chk("R6 second of back-to-back", rx_word, 8'h88);
        chk("R4 no overrun when read", {7'd0, err_overrun}, 8'h00);
        pulse(1, 0);

        // Line held low beyond a frame
        hold_bit(1'b0, 0, 12 * BIT_CLK);
        settle();
        chk("R7 break flagged", {7'd0, err_break}, 8'h01);
        chk("R7 no word on break", {7'd0, word_ready}, 8'h00);
        chk("R7 buffer untouched", rx_word, 8'h88);
        hold_bit(1'b1, 0, 64);
        send(8'h42, 8, 0, 0, 1, 0);
        hold_bit(1'b1, 0, 48);
        settle();
        chk("R7 reception resumes after break", rx_word, 8'h42);
        pulse(1, 1);
        settle();
        chk("R10 break cleared", {7'd0, err_break}, 8'h00);

        // Loopback with the external input held low
        @(negedge clk); loop_mode = 1'b1; ser_in = 1'b0;
        hold_bit(1'b1, 1, 48);
        send(8'h6E, 8, 0, 0, 1, 1);
        hold_bit(1'b1, 1, 48);
        settle();
        chk("R9 loopback word", rx_word, 8'h6E);
        chk("R9 loopback ready", {7'd0, word_ready}, 8'h01);
        chk("R9 ser_out at mark", {7'd0, ser_out}, 8'h01);
        pulse(1, 0);
        @(negedge clk); ser_in = 1'b1; loop_mode = 1'b0;
        hold_bit(1'b1, 0, 64);

        finish_run();
    end

endmodule